// File: doc/BRIEF.md
# Slave-Mode Up/Down Counter

A general-purpose counter whose stepping is governed by a 3-bit slave-mode code. In the three clock-driven modes it advances by one on every internal clock cycle in which it is allowed to run: always (while enabled), only while an external trigger is high, or from the first trigger rising edge onward. A software direction bit selects up or down counting in those modes. In the three encoder modes, two quadrature inputs supply both the count pulses and the direction, and the mode alone turns the counter on.

The count wraps between zero and a programmable auto-reload value, and a preset value can be loaded at any time. The trigger and both encoder inputs pass through a two-stage synchroniser before any level or edge is used, so a change on one of those pins first affects the count at the second rising clock edge after the edge that first samples it.

Top module: `slave_mode_counter`

## Requirements
- R1: While rst is high, and on the first cycle after it is released, cnt_value is 0.
- R2: When preset_load is high at a clock edge, cnt_value takes preset_val at that edge, taking priority over any counting step.
- R3: With cfg_mode = 0 and cfg_en = 1, the count changes by one on every clock edge: up when cfg_down = 0, down when cfg_down = 1. The trigger has no effect.
- R4: With cfg_mode = 5 and cfg_en = 1, the count steps only on edges where the synchronised trigger (trig_in delayed by two flip-flops) is high, and holds while it is low.
- R5: With cfg_mode = 6 and cfg_en = 1, the count holds until a rising edge of the synchronised trigger, then steps on every edge whatever the trigger does. Clearing cfg_en, or leaving mode 6, stops counting and re-arms the wait for a new rising edge.
- R6: With cfg_mode = 3, every single-input change of the synchronised (A,B) pair steps the count by one; the sequence 00, 10, 11, 01 (A written first) counts up and the reverse counts down. A change of both inputs at once does not count.
- R7: With cfg_mode = 1 only changes of A count (up when A differs from B afterwards); with cfg_mode = 2 only changes of B count (up when A equals B afterwards). Changes of the other input are ignored.
- R8: With cfg_mode = 4 or 7, or with cfg_en = 0 in modes 0, 5 and 6, the count holds its value.
- R9: Counting up from a count equal to cfg_reload gives 0.
- R10: Counting down from 0 gives cfg_reload.
- R11: In the encoder modes (1, 2, 3) counting does not depend on cfg_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Counter enable for modes 0, 5, 6 |
| cfg_mode | input | 3 | Slave-mode code |
| cfg_down | input | 1 | Direction in clock-driven modes: 0 up, 1 down |
| cfg_reload | input | CNT_W | Auto-reload (wrap) value |
| preset_load | input | 1 | Load preset_val into the counter |
| preset_val | input | CNT_W | Value to load |
| trig_in | input | 1 | Asynchronous trigger input |
| enc_a | input | 1 | Asynchronous encoder input A |
| enc_b | input | 1 | Asynchronous encoder input B |
| cnt_value | output | CNT_W | Current count |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_DEPTH = 2, and drives cfg_reload with small values (between 3 and 12), so both wrap directions occur dozens of times per run instead of once per 65536 steps. The 8-bit width also lets presets above the reload value wrap through the full range quickly. Keeping the synchroniser at two stages matches the latency the bench's cycle model of the requirements expects, so every cycle of every mode is compared exactly.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam logic [2:0] MODE_FREE   = 3'd0;
    localparam logic [2:0] MODE_ENC_A  = 3'd1;
    localparam logic [2:0] MODE_ENC_B  = 3'd2;
    localparam logic [2:0] MODE_ENC_AB = 3'd3;
    localparam logic [2:0] MODE_GATED  = 3'd5;
    localparam logic [2:0] MODE_TRIG   = 3'd6;

    typedef struct packed {
        logic go;
        logic up;
    } step_t;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    localparam step_t STEP_NONE = '{go: 1'b0, up: 1'b0};

    function automatic logic is_encoder(input logic [2:0] mode);
        return (mode == MODE_ENC_A) || (mode == MODE_ENC_B) || (mode == MODE_ENC_AB);
    endfunction

    function automatic logic is_clocked(input logic [2:0] mode);
        return (mode == MODE_FREE) || (mode == MODE_GATED) || (mode == MODE_TRIG);
    endfunction

    // One quadrature decision from the previous and current input pair.
    function automatic step_t quad_step(input quad_t prv, input quad_t cur,
                                        input logic use_a, input logic use_b);
        step_t s;
        logic  chg_a;
        logic  chg_b;
        chg_a = prv.a ^ cur.a;
        chg_b = prv.b ^ cur.b;
        s = STEP_NONE;
        if (use_a && chg_a && !chg_b) begin
            s.go = 1'b1;
            s.up = cur.a != cur.b;
        end else if (use_b && chg_b && !chg_a) begin
            s.go = 1'b1;
            s.up = cur.a == cur.b;
        end
        return s;
    endfunction

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
    parameter int N_BITS     = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] din,
    output logic [N_BITS-1:0] dout
);
    localparam int LAST = SYNC_DEPTH - 1;

    logic [N_BITS-1:0] stage [SYNC_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    generate
        for (genvar g = 1; g < SYNC_DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign dout = stage[LAST];
endmodule

// File: rtl/smc_quad_dec.sv
module smc_quad_dec
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  quad_t      pins,
    output step_t      step
);
    quad_t prev_q;
    logic  use_a;
    logic  use_b;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pins;
    end

    always_comb begin
        use_a = (mode == MODE_ENC_A) || (mode == MODE_ENC_AB);
        use_b = (mode == MODE_ENC_B) || (mode == MODE_ENC_AB);
        step  = quad_step(prev_q, pins, use_a, use_b);
    end
endmodule

// File: rtl/smc_trig_ctrl.sv
module smc_trig_ctrl
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       en,
    input  logic       down,
    input  logic       trig,
    output step_t      step
);
    logic trig_prev;
    logic trig_rise;
    logic running_q;
    logic running_d;

    assign trig_rise = trig && !trig_prev;
    assign running_d = en && (mode == MODE_TRIG) && (running_q || trig_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_prev <= 1'b0;
            running_q <= 1'b0;
        end else begin
            trig_prev <= trig;
            running_q <= running_d;
        end
    end

    always_comb begin
        step    = STEP_NONE;
        step.up = !down;
        if (en) begin
            case (mode)
                MODE_FREE:  step.go = 1'b1;
                MODE_GATED: step.go = trig;
                MODE_TRIG:  step.go = running_q;
                default:    step.go = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smc_core.sv
module smc_core
    import smc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic [CNT_W-1:0] reload,
    input  step_t            step,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_step;

    always_comb begin
        if (step.up) cnt_step = (cnt_q == reload) ? ZERO : cnt_q + ONE;
        else         cnt_step = (cnt_q == ZERO) ? reload : cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= ZERO;
        else if (load)    cnt_q <= preset;
        else if (step.go) cnt_q <= cnt_step;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/slave_mode_counter.sv
module slave_mode_counter
    import smc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_down,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic             preset_load,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             trig_in,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic [CNT_W-1:0] cnt_value
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] sync_in;
    quad_t              quad_s;
    step_t              enc_step;
    step_t              tim_step;
    step_t              sel_step;

    assign raw_in = {trig_in, enc_a, enc_b};

    smc_sync #(.N_BITS(N_ASYNC), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_in)
    );

    assign quad_s.a = sync_in[1];
    assign quad_s.b = sync_in[0];

    smc_quad_dec u_quad (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_mode),
        .pins (quad_s),
        .step (enc_step)
    );

    smc_trig_ctrl u_trig (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg_mode),
        .en   (cfg_en),
        .down (cfg_down),
        .trig (sync_in[2]),
        .step (tim_step)
    );

    always_comb begin
        if (is_encoder(cfg_mode))      sel_step = enc_step;
        else if (is_clocked(cfg_mode)) sel_step = tim_step;
        else                           sel_step = STEP_NONE;
    end

    smc_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (preset_load),
        .preset (preset_val),
        .reload (cfg_reload),
        .step   (sel_step),
        .cnt    (cnt_value)
    );
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic [2:0]       cfg_mode,
    input logic             cfg_down,
    input logic [CNT_W-1:0] cfg_reload,
    input logic             preset_load,
    input logic [CNT_W-1:0] preset_val,
    input logic [CNT_W-1:0] cnt_value
);
    logic run_free;
    assign run_free = !preset_load && (cfg_mode == 3'd0) && cfg_en;

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> cnt_value == '0); // R1
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        preset_load |=> cnt_value == $past(preset_val)); // R2
    AST_FREE_UP: assert property (@(posedge clk) disable iff (rst)
        (run_free && !cfg_down && cnt_value != cfg_reload) |=> cnt_value == $past(cnt_value) + 1'b1); // R3
    AST_HOLD_SPARE: assert property (@(posedge clk) disable iff (rst)
        (!preset_load && (cfg_mode == 3'd4 || cfg_mode == 3'd7)) |=> $stable(cnt_value)); // R8
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_free && !cfg_down && cnt_value == cfg_reload) |=> cnt_value == '0); // R9
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_free && cfg_down && cnt_value == '0) |=> cnt_value == $past(cfg_reload)); // R10
endmodule

bind slave_mode_counter smc_checker #(.CNT_W(CNT_W)) u_smc_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .cfg_mode    (cfg_mode),
    .cfg_down    (cfg_down),
    .cfg_reload  (cfg_reload),
    .preset_load (preset_load),
    .preset_val  (preset_val),
    .cnt_value   (cnt_value)
);

// File: tb/test_slave_mode_counter.sv
`timescale 1ns/1ps
module test_slave_mode_counter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic [2:0]   cfg_mode = 3'd0;
    logic         cfg_down = 1'b0;
    logic [W-1:0] cfg_reload = 8'd9;
    logic         preset_load = 1'b0;
    logic [W-1:0] preset_val = '0;
    logic         trig_in = 1'b0;
    logic         enc_a = 1'b0;
    logic         enc_b = 1'b0;
    logic [W-1:0] cnt_value;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    slave_mode_counter #(.CNT_W(W), .SYNC_DEPTH(2)) i_slave_mode_counter (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_down(cfg_down),
        .cfg_reload(cfg_reload), .preset_load(preset_load), .preset_val(preset_val),
        .trig_in(trig_in), .enc_a(enc_a), .enc_b(enc_b), .cnt_value(cnt_value)
    );

    // Cycle model built from the requirements
    logic         t1, t2, t3, a1, a2, a3, b1, b2, b3, m_run;
    logic [W-1:0] m_cnt;
    logic [2:0]   m_mode;
    logic         m_en, m_load, m_valid;

    function automatic logic [W-1:0] bump(input logic [W-1:0] c, input logic up,
                                          input logic [W-1:0] rl);
        if (up) return (c == rl) ? '0 : c + 1'b1;
        return (c == '0) ? rl : c - 1'b1;
    endfunction

    function automatic logic [W-1:0] model_next(input logic [W-1:0] c);
        logic ca, cb;
        ca = a2 ^ a3;
        cb = b2 ^ b3;
        if (preset_load) return preset_val;
        case (cfg_mode)
            3'd0: if (cfg_en) return bump(c, !cfg_down, cfg_reload);
            3'd5: if (cfg_en && t2) return bump(c, !cfg_down, cfg_reload);
            3'd6: if (cfg_en && m_run) return bump(c, !cfg_down, cfg_reload);
            3'd1: if (ca && !cb) return bump(c, a2 != b2, cfg_reload);
            3'd2: if (cb && !ca) return bump(c, a2 == b2, cfg_reload);
            3'd3: begin
                if (ca && !cb) return bump(c, a2 != b2, cfg_reload);
                if (cb && !ca) return bump(c, a2 == b2, cfg_reload);
            end
            default: ;
        endcase
        return c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {t1, t2, t3, a1, a2, a3, b1, b2, b3, m_run} <= '0;
            m_cnt <= '0; m_valid <= 1'b1; m_load <= 1'b0;
            m_mode <= 3'd0; m_en <= 1'b0;
        end else begin
            t1 <= trig_in; t2 <= t1; t3 <= t2;
            a1 <= enc_a;   a2 <= a1; a3 <= a2;
            b1 <= enc_b;   b2 <= b1; b3 <= b2;
            m_run  <= cfg_en && cfg_mode == 3'd6 && (m_run || (t2 && !t3));
            m_cnt  <= model_next(m_cnt);
            m_mode <= cfg_mode; m_en <= cfg_en; m_load <= preset_load;
        end
    end

    function automatic string tag_of(input logic [2:0] md, input logic en, input logic ld);
        if (ld) return "R2";
        case (md)
            3'd0: return en ? "R3" : "R8";
            3'd5: return en ? "R4" : "R8";
            3'd6: return en ? "R5" : "R8";
            3'd3: return en ? "R6" : "R11";
            3'd1, 3'd2: return en ? "R7" : "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cnt_value actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && m_valid && !done)
            check(tag_of(m_mode, m_en, m_load), cnt_value, m_cnt);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_preset(input logic [W-1:0] v);
        @(negedge clk); preset_load = 1'b1; preset_val = v;
        @(negedge clk); preset_load = 1'b0;
    endtask

    // Next quadrature state in the up order 00,10,11,01 (A first)
    task automatic quad_move(input logic up);
        logic [1:0] s;
        s = {enc_a, enc_b};
        if (up) begin
            case (s) 2'b00: s = 2'b10; 2'b10: s = 2'b11; 2'b11: s = 2'b01; default: s = 2'b00; endcase
        end else begin
            case (s) 2'b00: s = 2'b01; 2'b01: s = 2'b11; 2'b11: s = 2'b10; default: s = 2'b00; endcase
        end
        {enc_a, enc_b} = s;
    endtask

    logic [W-1:0] snap;

    initial begin
        void'($urandom(32'h5A17C0DE));
        m_valid = 1'b0;
        cyc(3);
        check("R1", cnt_value, '0);
        @(negedge clk); rst = 1'b0;
        check("R1", cnt_value, '0);

        // R2 / R9: preset to reload then one up step wraps to zero
        cfg_reload = 8'd9; cfg_mode = 3'd0; cfg_en = 1'b1; cfg_down = 1'b0;
        do_preset(8'd9);
        check("R2", cnt_value, 8'd9);
        cyc(1);
        check("R9", cnt_value, 8'd0);
        // R10: preset zero, count down, lands on reload
        cfg_down = 1'b1;
        do_preset(8'd0);
        check("R2", cnt_value, 8'd0);
        cyc(1);
        check("R10", cnt_value, 8'd9);
        cyc(25);

        // R8: enable low holds; spare codes hold
        cfg_en = 1'b0; cyc(2); snap = cnt_value; cyc(6);
        check("R8", cnt_value, snap);
        cfg_en = 1'b1; cfg_mode = 3'd4; trig_in = 1'b1; cyc(2); snap = cnt_value;
        for (int i = 0; i < 8; i++) begin quad_move(1'b1); cyc(1); end
        check("R8", cnt_value, snap);
        cfg_mode = 3'd7; cyc(6);
        check("R8", cnt_value, snap);

        // R4: gated
        cfg_mode = 3'd5; cfg_down = 1'b0; cfg_reload = 8'd12;
        for (int i = 0; i < 60; i++) begin trig_in = $urandom_range(0, 1); cyc($urandom_range(1, 4)); end

        // R5: triggered start, run after trigger drop, stop and re-arm
        trig_in = 1'b0; cfg_mode = 3'd6; cyc(4); snap = cnt_value; cyc(4);
        check("R5", cnt_value, snap);
        trig_in = 1'b1; cyc(1); trig_in = 1'b0; cyc(12);
        cfg_en = 1'b0; cyc(2); snap = cnt_value;
        cfg_en = 1'b1; cyc(6);
        check("R5", cnt_value, snap);
        trig_in = 1'b1; cyc(8);

        // R6 / R7 / R11: encoder modes, enable toggled freely
        for (int md = 1; md <= 3; md++) begin
            cfg_mode = 3'(md);
            for (int i = 0; i < 80; i++) begin
                cfg_en = $urandom_range(0, 1);
                quad_move($urandom_range(0, 3) != 0);
                cyc($urandom_range(1, 3));
            end
        end
        // R11: encoder counts with enable low
        cfg_mode = 3'd3; cfg_en = 1'b0; cyc(3); snap = cnt_value;
        quad_move(1'b1); cyc(4);
        check("R11", cnt_value, (snap == cfg_reload) ? 8'd0 : snap + 8'd1);
        // R6: simultaneous change of both inputs is ignored
        snap = cnt_value; enc_a = ~enc_a; enc_b = ~enc_b; cyc(4);
        check("R6", cnt_value, snap);

        // Random mix of everything
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) begin
                case ($urandom_range(0, 7))
                    0: cfg_mode = 3'd0; 1: cfg_mode = 3'd1; 2: cfg_mode = 3'd2; 3: cfg_mode = 3'd3;
                    4: cfg_mode = 3'd4; 5: cfg_mode = 3'd5; 6: cfg_mode = 3'd6; default: cfg_mode = 3'd7;
                endcase
                cfg_reload = 8'($urandom_range(3, 12));
            end
            if ($urandom_range(0, 9) == 0) cfg_en = ~cfg_en;
            if ($urandom_range(0, 19) == 0) cfg_down = ~cfg_down;
            if ($urandom_range(0, 5) == 0) trig_in = ~trig_in;
            if ($urandom_range(0, 2) == 0) quad_move($urandom_range(0, 1) != 0);
            preset_load = ($urandom_range(0, 40) == 0);
            preset_val  = 8'($urandom_range(0, 255));
        end
        preset_load = 1'b0;
        cyc(3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule